// File: doc/BRIEF.md
# NAL Byte Stream Packer

This block turns a stream of variable-length coded fields (1 to 64 bits each) into byte-stream network abstraction layer units. The output is a sequence of 32-bit words. An upstream encoder sends three kinds of command on one valid/ready channel:

- An open command carries a unit type, a reference indicator and a flag that asks for an extra zero byte. The packer answers with the start code and the one-byte unit header.
- Data commands carry the coded fields. The packer joins them into bytes, most significant bit first. As each payload byte passes, it inserts the 0x03 escape byte wherever a start code could appear.
- A close command makes the packer write the stop bit, fill the rest of that byte with zeros, and then add zero bytes until the unit ends on a word boundary.

The output side has no back-pressure. A word is presented for one cycle with a valid strobe. The input is held off, by dropping ready, while the packer is writing prefix, escape, final or padding bytes, or still has whole payload bytes to drain.

Top module: `nal_packer`

## Requirements
- R1: After an open command, the unit begins with the bytes 0x00, 0x00, 0x01 and then the header byte.
- R2: The header byte is, from bit 7 down to bit 0: a zero bit, the 2-bit reference indicator, and the 5-bit unit type. For example, type 7 with reference 3 gives 0x67, and type 11 with reference 0 gives 0x0B.
- R3: When the open command has its zero-byte flag set, one extra 0x00 byte comes before the start code. When the flag is clear, no byte comes before it.
- R4: Each data field holds its `in_len` low bits of `in_bits`, sent most significant bit first. Bits above `in_len` are discarded. Fields are joined with no gaps, across byte boundaries.
- R5: When two payload 0x00 bytes are followed by a payload byte of value 0x00 to 0x03, a 0x03 byte is placed before that third byte. The inserted byte resets the zero count.
- R6: The zero count used for R5 starts from zero in every unit and counts only payload bytes. A 0x00 header byte does not add to it.
- R7: A close command ends the payload with one 1 bit followed by zero bits up to the byte boundary. If the payload is already byte-aligned, this final byte is 0x80. The final byte is subject to R5.
- R8: After the final byte, 0x00 bytes are added until the unit's total byte count is a multiple of four. The packer then returns to idle.
- R9: `in_ready` is low while the packer is writing prefix, header, escape, final or padding bytes. It is also low while whole payload bytes are still pending.
- R10: A data or close command received while no unit is open is consumed and has no effect on the output. An open command received inside a unit is also consumed and has no effect.
- R11: Output bytes fill each word from bit 31 downward, so the earliest byte is in bits 31:24. `word_valid` is high for exactly one cycle per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command valid |
| in_ready | output | 1 | Command accepted when high together with in_valid |
| in_kind | input | 2 | 0 = data field, 1 = open unit, 2 = close unit |
| in_bits | input | 64 | Field bits, right-aligned |
| in_len | input | 7 | Field length in bits, 1 to 64 |
| in_unit_type | input | 5 | Unit type for the header (open command) |
| in_ref_idc | input | 2 | Reference indicator for the header (open command) |
| in_zero_byte | input | 1 | Emit an extra zero byte before the start code (open command) |
| word_data | output | 32 | Packed output word |
| word_valid | output | 1 | word_data is valid this cycle |

## Verification
The bench goes after the places where the escape rule is easy to get wrong:

- Runs of three or more zero bytes. A design that does not reset the count after an escape will insert one byte too many or too few.
- A final byte of 0x01 that follows two zero bytes. A design that skips the escape check on the stop byte lets a start code appear in the output.
- A 0x00 header byte followed by payload 0x00 0x01. A design that counts header bytes escapes a byte it must leave alone.

Other cases cover a 64-bit field that crosses many byte boundaries, a byte-aligned close that must produce 0x80, and a unit with no payload that needs three padding bytes. Stray commands sent while idle must leave the next unit's bytes unchanged.

// File: rtl/nal_pkg.sv
package nal_pkg;
   typedef enum logic [1:0] {
      CMD_DATA  = 2'd0,
      CMD_OPEN  = 2'd1,
      CMD_CLOSE = 2'd2
   } cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_BODY,
      ST_TAIL,
      ST_PAD
   } pk_state_e;

   localparam logic [7:0] ESC_BYTE  = 8'h03;
   localparam logic [7:0] SC_ONE    = 8'h01;
endpackage

// File: rtl/nal_bit_accum.sv
module nal_bit_accum #(
   parameter int ELEM_W = 64,
   parameter int LEN_W  = $clog2(ELEM_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ELEM_W-1:0] load_bits,
   input  logic [LEN_W-1:0]  load_len,
   input  logic              pop,
   input  logic              clear,
   output logic              have_byte,
   output logic [7:0]        top_byte,
   output logic [7:0]        final_byte
);
   localparam int ACC_W = ELEM_W + 8;
   localparam int CNT_W = $clog2(ACC_W + 1);

   logic [ACC_W-1:0] acc;
   logic [CNT_W-1:0] cnt;
   logic [ACC_W-1:0] wide;
   logic [ACC_W-1:0] placed;
   logic [LEN_W-1:0] lsh;

   always_comb begin
      wide   = {load_bits, 8'h00};
      lsh    = LEN_W'(ELEM_W) - load_len;
      placed = (wide << lsh) >> cnt;
   end

   assign have_byte  = (cnt >= CNT_W'(8));
   assign top_byte   = acc[ACC_W-1 -: 8];
   assign final_byte = acc[ACC_W-1 -: 8] | (8'h80 >> cnt[2:0]);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         acc <= '0;
         cnt <= '0;
      end else if (load) begin
         acc <= acc | placed;
         cnt <= cnt + CNT_W'(load_len);
      end else if (pop) begin
         acc <= acc << 8;
         cnt <= cnt - CNT_W'(8);
      end
   end

   assert_load_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (cnt < CNT_W'(8)));
   assert_pop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt >= CNT_W'(8)));
endmodule

// File: rtl/nal_escape_guard.sv
module nal_escape_guard (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic [7:0] cand,
   input  logic       pass_fire,
   input  logic       esc_fire,
   output logic       need_esc
);
   localparam int RUN_W = 2;
   localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(2);

   logic [RUN_W-1:0] zrun;

   assign need_esc = (zrun >= RUN_LIM) && (cand <= 8'h03);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)      zrun <= '0;
      else if (esc_fire)      zrun <= '0;
      else if (pass_fire) begin
         if (cand != 8'h00)   zrun <= '0;
         else if (zrun < RUN_LIM) zrun <= zrun + RUN_W'(1);
      end
   end
endmodule

// File: rtl/nal_word_builder.sv
module nal_word_builder #(
   parameter int WORD_BYTES = 4,
   parameter int BC_W       = $clog2(WORD_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_en,
   input  logic [7:0]              byte_val,
   output logic [BC_W-1:0]         bcnt,
   output logic [WORD_BYTES*8-1:0] word_data,
   output logic                    word_valid
);
   localparam int SH_W = (WORD_BYTES - 1) * 8;

   if (WORD_BYTES < 2) begin : g_bad_width
      $error("nal_word_builder: WORD_BYTES must be at least 2");
   end

   logic [SH_W-1:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg      <= '0;
         bcnt       <= '0;
         word_data  <= '0;
         word_valid <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         if (byte_en) begin
            if (bcnt == BC_W'(WORD_BYTES - 1)) begin
               word_data  <= {shreg, byte_val};
               word_valid <= 1'b1;
               bcnt       <= '0;
            end else begin
               shreg <= SH_W'({shreg, byte_val});
               bcnt  <= bcnt + BC_W'(1);
            end
         end
      end
   end

   assert_word_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);
endmodule

// File: rtl/nal_packer.sv
module nal_packer
   import nal_pkg::*;
#(
   parameter int ELEM_W     = 64,
   parameter int LEN_W      = $clog2(ELEM_W + 1),
   parameter int WORD_BYTES = 4,
   parameter int WORD_W     = WORD_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_kind,
   input  logic [ELEM_W-1:0] in_bits,
   input  logic [LEN_W-1:0]  in_len,
   input  logic [4:0]        in_unit_type,
   input  logic [1:0]        in_ref_idc,
   input  logic              in_zero_byte,
   output logic [WORD_W-1:0] word_data,
   output logic              word_valid
);
   localparam int BC_W = $clog2(WORD_BYTES);

   if (ELEM_W < 8) begin : g_bad_elem
      $error("nal_packer: ELEM_W must be at least 8");
   end

   pk_state_e       state;
   logic [2:0]      seq_idx;
   logic [7:0]      hdr_q;
   cmd_e            kind;

   logic            have_byte, need_esc;
   logic [7:0]      top_byte, final_byte, cand;
   logic            load, pop, acc_clear;
   logic            esc_fire, pass_fire;
   logic            byte_en;
   logic [7:0]      byte_val;
   logic [BC_W-1:0] bcnt;

   assign kind = cmd_e'(in_kind);
   assign cand = (state == ST_TAIL) ? final_byte : top_byte;

   always_comb begin
      in_ready  = 1'b0;
      load      = 1'b0;
      pop       = 1'b0;
      acc_clear = 1'b0;
      esc_fire  = 1'b0;
      pass_fire = 1'b0;
      byte_en   = 1'b0;
      byte_val  = 8'h00;
      unique case (state)
         ST_IDLE: in_ready = 1'b1;
         ST_PRE: begin
            byte_en  = 1'b1;
            byte_val = (seq_idx == 3'd4) ? hdr_q :
                       (seq_idx == 3'd3) ? SC_ONE : 8'h00;
         end
         ST_BODY: begin
            if (have_byte) begin
               byte_en = 1'b1;
               if (need_esc) begin
                  byte_val = ESC_BYTE;
                  esc_fire = 1'b1;
               end else begin
                  byte_val  = cand;
                  pass_fire = 1'b1;
                  pop       = 1'b1;
               end
            end else begin
               in_ready = 1'b1;
               load     = in_valid && (kind == CMD_DATA);
            end
         end
         ST_TAIL: begin
            byte_en = 1'b1;
            if (need_esc) begin
               byte_val = ESC_BYTE;
               esc_fire = 1'b1;
            end else begin
               byte_val  = cand;
               pass_fire = 1'b1;
               acc_clear = 1'b1;
            end
         end
         ST_PAD: byte_en = (bcnt != '0);
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         seq_idx <= '0;
         hdr_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (in_valid && kind == CMD_OPEN) begin
               hdr_q   <= {1'b0, in_ref_idc, in_unit_type};
               seq_idx <= in_zero_byte ? 3'd0 : 3'd1;
               state   <= ST_PRE;
            end
            ST_PRE: begin
               if (seq_idx == 3'd4) state <= ST_BODY;
               seq_idx <= seq_idx + 3'd1;
            end
            ST_BODY: if (!have_byte && in_valid && kind == CMD_CLOSE)
               state <= ST_TAIL;
            ST_TAIL: if (!need_esc) state <= ST_PAD;
            ST_PAD:  if (bcnt == '0) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   nal_bit_accum #(.ELEM_W(ELEM_W), .LEN_W(LEN_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .load(load), .load_bits(in_bits),
      .load_len(in_len), .pop(pop), .clear(acc_clear),
      .have_byte(have_byte), .top_byte(top_byte), .final_byte(final_byte)
   );

   nal_escape_guard u_esc (
      .clk(clk), .rst_n(rst_n), .clr(state == ST_PRE), .cand(cand),
      .pass_fire(pass_fire), .esc_fire(esc_fire), .need_esc(need_esc)
   );

   nal_word_builder #(.WORD_BYTES(WORD_BYTES), .BC_W(BC_W)) u_word (
      .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .byte_val(byte_val),
      .bcnt(bcnt), .word_data(word_data), .word_valid(word_valid)
   );

   // R5: an escape byte is always followed by the low-valued byte it guards
   assert_escape_then_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      esc_fire |=> (pass_fire && byte_en && byte_val <= 8'h03));
   // R8: leaving padding only on a word boundary
   assert_pad_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && $past(state) == ST_PAD) |-> (bcnt == '0));
endmodule

// File: tb/sim_nal_packer.sv
module sim_nal_packer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_kind = '0;
   logic [63:0] in_bits = '0;
   logic [6:0]  in_len = '0;
   logic [4:0]  in_unit_type = '0;
   logic [1:0]  in_ref_idc = '0;
   logic        in_zero_byte = 1'b0;
   logic [31:0] word_data;
   logic        word_valid;

   int n_checks = 0;
   int n_fails  = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   bit         bitq[$];
   int         zr = 0;
   int         nbytes = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nal_packer u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .in_bits(in_bits), .in_len(in_len),
      .in_unit_type(in_unit_type), .in_ref_idc(in_ref_idc),
      .in_zero_byte(in_zero_byte), .word_data(word_data), .word_valid(word_valid)
   );

   function automatic void check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endfunction

   function automatic void push_exp(logic [7:0] b, string t);
      exp_q.push_back(b);
      tag_q.push_back(t);
      nbytes++;
   endfunction

   function automatic void pay_byte(logic [7:0] b, string t);
      if (zr >= 2 && b <= 8'h03) begin
         push_exp(8'h03, "R5");
         zr = 0;
      end
      push_exp(b, t);
      zr = (b == 8'h00) ? zr + 1 : 0;
   endfunction

   task automatic xfer(logic [1:0] k, logic [63:0] b, logic [6:0] l,
                       logic [4:0] t, logic [1:0] r, logic z);
      @(negedge clk);
      in_valid = 1'b1; in_kind = k; in_bits = b; in_len = l;
      in_unit_type = t; in_ref_idc = r; in_zero_byte = z;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic open_unit(logic [4:0] t, logic [1:0] r, logic z);
      if (z) push_exp(8'h00, "R3");
      push_exp(8'h00, "R1");
      push_exp(8'h00, "R1");
      push_exp(8'h01, "R1");
      push_exp({1'b0, r, t}, "R2");
      zr = 0;
      bitq.delete();
      xfer(2'd1, '0, '0, t, r, z);
      check(in_ready == 1'b0, "R9 ready during prefix", {31'd0, in_ready}, 32'd0);
   endtask

   task automatic data(logic [63:0] b, int l, string t);
      for (int i = l - 1; i >= 0; i--) bitq.push_back(b[i]);
      while (bitq.size() >= 8) begin
         logic [7:0] v;
         for (int j = 0; j < 8; j++) v[7-j] = bitq.pop_front();
         pay_byte(v, t);
      end
      xfer(2'd0, b, 7'(l), '0, '0, 1'b0);
   endtask

   task automatic close_unit();
      logic [7:0] v;
      int n;
      v = 8'h00;
      n = bitq.size();
      for (int i = 0; i < n; i++) v[7-i] = bitq[i];
      v[7-n] = 1'b1;
      pay_byte(v, "R7");
      bitq.delete();
      while (nbytes % 4 != 0) push_exp(8'h00, "R8");
      xfer(2'd2, '0, '0, '0, '0, 1'b0);
   endtask

   // monitor: R11 lane order, earliest byte in bits 31:24
   always @(negedge clk) begin
      if (rst_n && word_valid) begin
         for (int l = 0; l < 4; l++) begin
            logic [7:0] g;
            g = word_data[31-8*l -: 8];
            if (exp_q.size() == 0) begin
               check(1'b0, "R11 unexpected byte", {24'd0, g}, 32'd0);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(g == e, $sformatf("%s lane %0d", t, l), {24'd0, g}, {24'd0, e});
            end
         end
      end
   end

   initial begin
      bit timed_out;
      timed_out = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(word_valid == 1'b0, "R11 reset valid", {31'd0, word_valid}, 32'd0);
      check(in_ready == 1'b1, "R9 idle ready", {31'd0, in_ready}, 32'd1);

      fork
         begin
            // parameter-set unit with mixed field lengths, one 64-bit
            open_unit(5'd7, 2'd3, 1'b1);
            data(64'h42, 8, "R4");
            data(64'b101, 3, "R4");
            data(64'hFFFF_FFFF_FFFF_FF12, 5, "R4");
            data(64'h0123_4567_89AB_CDEF, 64, "R4");
            data(64'h5, 4, "R4");
            close_unit();
            // escapes: 00 00 01, zero run of five, aligned close -> 0x80
            open_unit(5'd8, 2'd3, 1'b1);
            data(64'h0000_0102, 32, "R5");
            data(64'h00_0000_0000, 40, "R5");
            data(64'hAB, 8, "R5");
            close_unit();
            // stop byte 0x01 after two zero bytes needs escape
            open_unit(5'd5, 2'd3, 1'b0);
            data(64'h0000, 16, "R7");
            data(64'h0, 7, "R7");
            close_unit();
            // zero header byte must not count toward zero run
            open_unit(5'd0, 2'd0, 1'b0);
            data(64'h0001, 16, "R6");
            close_unit();
            // stray commands while idle have no effect
            xfer(2'd0, 64'hFF, 7'd8, '0, '0, 1'b0);
            xfer(2'd2, '0, '0, '0, '0, 1'b0);
            open_unit(5'd1, 2'd0, 1'b0);
            data(64'h3C, 8, "R10");
            xfer(2'd1, '0, '0, 5'd9, 2'd1, 1'b1);
            data(64'h7, 3, "R10");
            close_unit();
            // end-of-stream with no payload: 0x80 then padding
            open_unit(5'd11, 2'd0, 1'b0);
            close_unit();
            repeat (20) @(posedge clk);
         end
         begin
            repeat (20000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;

      if (timed_out) check(1'b0, "watchdog", 32'd0, 32'd1);
      check(exp_q.size() == 0, "R8 all expected bytes seen", exp_q.size(), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule